// File: doc/BRIEF.md
# Legacy Configuration Port Interface

This block is an 8-bit I/O-port slave that gives a host access to a configuration space through two adjacent ports. The port at the base address holds an index. The port one address above it reads or writes the register that the index selects. The base address is a fixed choice between two port pairs, picked by a strap input.

The block comes out of reset locked. While it is locked, the only thing it does is watch the index port for a key sequence. Two consecutive writes of the entry key open it. A single write of the exit key locks it again.

While the block is open, a small set of global registers answers directly: the logical device select register, a two-byte chip identifier, a revision byte and a two-byte manufacturer identifier. Every index from 0x30 upward is passed to an attached per-device register file. The forwarded access carries the index, the current logical device number and the write data, and the read data comes back from the register file.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked, and both the index register and the logical device register hold 0x00.
- R2: While the block is locked, reads of either port return 0xFF. Writes to either port change no register and raise no device strobe. The one exception is key detection on the index port.
- R3: The block opens only after two index-port writes of 0x87 in a row. Any other value written to the index port after the first 0x87 makes the sequence start again.
- R4: While the block is open, an index-port write of 0xAA locks it. That write does not load the index, and the index and logical device registers keep their values.
- R5: With `baseSel` = 0 the index port is at 0x002E and the data port at 0x002F. With `baseSel` = 1 they are at 0x004E and 0x004F. Accesses to any other address are ignored and read 0xFF.
- R6: While the block is open, an index-port write loads the index, and an index-port read returns it. With index 0x07, a data write sets the logical device number and a data read returns it.
- R7: The chip identifier reads as its high byte at index 0x20 and its low byte at index 0x21 (default 0x5A3C). The revision reads at index 0x22 (default 0x11).
- R8: The manufacturer identifier reads as its high byte at index 0x23 and its low byte at index 0x24, with value 0x1934.
- R9: For an index of 0x30 or above, a data write pulses `devWr` with `devLdn`, `devIndex` and `devWrData`. A data read pulses `devRd`, and `ioRdData` returns `devRdData` in the same cycle.
- R10: Indexes below 0x30 other than 0x07 and 0x20 to 0x24 read 0xFF. Data writes to them change nothing and raise no device strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseSel | input | 1 | Strap that selects the base port pair (0: 0x2E, 1: 0x4E) |
| ioAddr | input | 16 | I/O port address |
| ioWr | input | 1 | Single-cycle I/O write strobe |
| ioRd | input | 1 | I/O read strobe; read data is valid in the same cycle |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data (0xFF when nothing answers) |
| devWr | output | 1 | Write strobe to the per-device register file |
| devRd | output | 1 | Read strobe to the per-device register file |
| devLdn | output | 8 | Current logical device number |
| devIndex | output | 8 | Current configuration index |
| devWrData | output | 8 | Write data to the per-device register file |
| devRdData | input | 8 | Read data from the per-device register file |

## Verification
The embedded assertions check the following on every cycle:
- no data or device strobe occurs while the block is not open;
- the block never goes straight from locked to open;
- an open-state write of the exit key always relocks the block;
- forwarded strobes only carry indexes of 0x30 and above;
- the logical device register only changes on a data write at index 0x07.

Only the bench scenarios can show the rest:
- that an interrupted key sequence restarts;
- the exact register read values;
- that writes are ignored on the inactive port pair;
- that index and device state survive a lock and unlock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int DATA_W = 8;

  // Register indexes whose positions the host software decodes.
  localparam logic [DATA_W-1:0] IDX_LDN      = 8'h07;
  localparam logic [DATA_W-1:0] IDX_CHIP_HI  = 8'h20;
  localparam logic [DATA_W-1:0] IDX_CHIP_LO  = 8'h21;
  localparam logic [DATA_W-1:0] IDX_REV      = 8'h22;
  localparam logic [DATA_W-1:0] IDX_VEND_HI  = 8'h23;
  localparam logic [DATA_W-1:0] IDX_VEND_LO  = 8'h24;
  localparam logic [DATA_W-1:0] IDX_DEV_BASE = 8'h30;
  localparam logic [DATA_W-1:0] IDLE_BYTE    = 8'hFF;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_t;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic open;     // block is unlocked
    logic idxLoad;  // load the index register from write data
    logic dataWr;   // data-port write while open
    logic rdIdx;    // index-port read (any lock state)
    logic rdData;   // data-port read (any lock state)
  } cfg_strobe_t;

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_A    = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_B    = 16'h004E,
  parameter logic [DATA_W-1:0] ENTER_KEY = 8'h87,
  parameter logic [DATA_W-1:0] EXIT_KEY  = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseSel,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWrData,
  output cfg_strobe_t       strobe
);

  localparam logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(1);

  key_state_t keyState, keyNext;
  logic [ADDR_W-1:0] baseAddr;
  logic hitIdx, hitData;
  logic idxWr, isEnter, isExit;

  assign baseAddr = baseSel ? BASE_B : BASE_A;
  assign hitIdx   = (ioAddr == baseAddr);
  assign hitData  = (ioAddr == baseAddr + DATA_OFS);
  assign idxWr    = ioWr && hitIdx;
  assign isEnter  = (ioWrData == ENTER_KEY);
  assign isExit   = (ioWrData == EXIT_KEY);

  // Key sequence tracker
  always_comb begin
    keyNext = keyState;
    case (keyState)
      KEY_LOCKED: if (idxWr && isEnter) keyNext = KEY_HALF;
      KEY_HALF:   if (idxWr) keyNext = isEnter ? KEY_OPEN : KEY_LOCKED;
      KEY_OPEN:   if (idxWr && isExit) keyNext = KEY_LOCKED;
      default:    keyNext = KEY_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) keyState <= KEY_LOCKED;
    else       keyState <= keyNext;
  end

  always_comb begin
    strobe.open    = (keyState == KEY_OPEN);
    strobe.idxLoad = strobe.open && idxWr && !isExit;
    strobe.dataWr  = strobe.open && ioWr && hitData;
    strobe.rdIdx   = ioRd && hitIdx;
    strobe.rdData  = ioRd && hitData;
  end

  AST_NO_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (keyState != KEY_OPEN) |-> (!strobe.dataWr && !strobe.idxLoad)); // R2

  AST_NO_SINGLE_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KEY_LOCKED) |=> (keyState != KEY_OPEN)); // R3

  AST_EXIT_RELOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KEY_OPEN && idxWr && isExit) |=> (keyState == KEY_LOCKED)); // R4

endmodule

// File: rtl/sio_cfg_dp.sv
module sio_cfg_dp
  import sio_cfg_pkg::*;
#(
  parameter logic [2*DATA_W-1:0] CHIP_ID   = 16'h5A3C,
  parameter logic [DATA_W-1:0]   CHIP_REV  = 8'h11,
  parameter logic [2*DATA_W-1:0] VENDOR_ID = 16'h1934
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobe,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic              devWr,
  output logic              devRd,
  output logic [DATA_W-1:0] devLdn,
  output logic [DATA_W-1:0] devIndex,
  output logic [DATA_W-1:0] devWrData,
  input  logic [DATA_W-1:0] devRdData
);

  localparam int ID_BYTES = 2;

  logic [DATA_W-1:0] idxReg, ldnReg, globalByte;
  logic [DATA_W-1:0] chipByte [ID_BYTES];
  logic [DATA_W-1:0] vendByte [ID_BYTES];
  logic isDevIdx;

  // Identifier bytes, high byte first.
  for (genvar b = 0; b < ID_BYTES; b++) begin : g_idBytes
    assign chipByte[b] = CHIP_ID[(ID_BYTES-1-b)*DATA_W +: DATA_W];
    assign vendByte[b] = VENDOR_ID[(ID_BYTES-1-b)*DATA_W +: DATA_W];
  end

  assign isDevIdx = (idxReg >= IDX_DEV_BASE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
      ldnReg <= '0;
    end else begin
      if (strobe.idxLoad) idxReg <= ioWrData;
      if (strobe.dataWr && idxReg == IDX_LDN) ldnReg <= ioWrData;
    end
  end

  // Global register read mux
  always_comb begin
    case (idxReg)
      IDX_LDN:     globalByte = ldnReg;
      IDX_CHIP_HI: globalByte = chipByte[0];
      IDX_CHIP_LO: globalByte = chipByte[1];
      IDX_REV:     globalByte = CHIP_REV;
      IDX_VEND_HI: globalByte = vendByte[0];
      IDX_VEND_LO: globalByte = vendByte[1];
      default:     globalByte = IDLE_BYTE;
    endcase
  end

  always_comb begin
    ioRdData = IDLE_BYTE;
    if (strobe.open) begin
      if (strobe.rdIdx)       ioRdData = idxReg;
      else if (strobe.rdData) ioRdData = isDevIdx ? devRdData : globalByte;
    end
  end

  assign devWr     = strobe.dataWr && isDevIdx;
  assign devRd     = strobe.open && strobe.rdData && isDevIdx;
  assign devLdn    = ldnReg;
  assign devIndex  = idxReg;
  assign devWrData = ioWrData;

  AST_LOCKED_IDLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.open |-> (ioRdData == IDLE_BYTE && !devWr && !devRd)); // R2

  AST_FWD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (devWr || devRd) |-> (devIndex >= IDX_DEV_BASE)); // R9

  AST_LDN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dataWr && idxReg == IDX_LDN) |=> $stable(ldnReg)); // R10

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int                  ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]   BASE_A    = 16'h002E,
  parameter logic [ADDR_W-1:0]   BASE_B    = 16'h004E,
  parameter logic [7:0]          ENTER_KEY = 8'h87,
  parameter logic [7:0]          EXIT_KEY  = 8'hAA,
  parameter logic [15:0]         CHIP_ID   = 16'h5A3C,
  parameter logic [7:0]          CHIP_REV  = 8'h11,
  parameter logic [15:0]         VENDOR_ID = 16'h1934
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseSel,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic              devWr,
  output logic              devRd,
  output logic [7:0]        devLdn,
  output logic [7:0]        devIndex,
  output logic [7:0]        devWrData,
  input  logic [7:0]        devRdData
);

  cfg_strobe_t strobe;

  sio_cfg_ctrl #(
    .ADDR_W   (ADDR_W),
    .BASE_A   (BASE_A),
    .BASE_B   (BASE_B),
    .ENTER_KEY(ENTER_KEY),
    .EXIT_KEY (EXIT_KEY)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .baseSel (baseSel),
    .ioAddr  (ioAddr),
    .ioWr    (ioWr),
    .ioRd    (ioRd),
    .ioWrData(ioWrData),
    .strobe  (strobe)
  );

  sio_cfg_dp #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV),
    .VENDOR_ID(VENDOR_ID)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ioWrData (ioWrData),
    .ioRdData (ioRdData),
    .devWr    (devWr),
    .devRd    (devRd),
    .devLdn   (devLdn),
    .devIndex (devIndex),
    .devWrData(devWrData),
    .devRdData(devRdData)
  );

endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseSel = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        devWr, devRd;
  logic [7:0]  devLdn, devIndex, devWrData, devRdData;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk; // 125 MHz

  // Attached register file model: data is a fixed function of the index.
  assign devRdData = devIndex ^ 8'hA5;

  sio_cfg_port dut_i (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .ioAddr(ioAddr),
    .ioWr(ioWr), .ioRd(ioRd), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .devWr(devWr), .devRd(devRd), .devLdn(devLdn), .devIndex(devIndex),
    .devWrData(devWrData), .devRdData(devRdData)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Driver: read pushes its expectation for the monitor.
  task automatic ioRead(input logic [15:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  // Driver: write, checking the forwarded strobe in the same cycle.
  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d,
                         input logic expDev, input logic [7:0] expLdn, input string tag);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    #2;
    checks++;
    if (devWr !== expDev) begin
      errors++;
      $display("FAIL %s: devWr=%0b expected %0b", tag, devWr, expDev);
    end
    if (expDev) begin
      checks++;
      if (devLdn !== expLdn || devIndex !== dut_idx_exp || devWrData !== d) begin
        errors++;
        $display("FAIL %s: ldn/idx/data=%02h/%02h/%02h expected %02h/%02h/%02h",
                 tag, devLdn, devIndex, devWrData, expLdn, dut_idx_exp, d);
      end
    end
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  logic [7:0] dut_idx_exp = 8'h00; // index the bench expects the block to hold

  // Monitor: compares each read result against the queue.
  always begin
    @(negedge clk);
    #2;
    if (ioRd) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL monitor: unexpected read got %02h expected none", ioRdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (ioRdData !== e) begin
          errors++;
          $display("FAIL %s: got %02h expected %02h", t, ioRdData, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung got timeout expected completion");
    finish_run();
  end

  localparam logic [15:0] IA = 16'h002E, DA = 16'h002F;
  localparam logic [15:0] IB = 16'h004E, DB = 16'h004F;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R2: locked after reset
    ioRead(DA, 8'hFF, "R2 locked data read");
    ioRead(IA, 8'hFF, "R1 locked index read");
    ioWrite(DA, 8'h55, 1'b0, 8'h00, "R2 locked data write no strobe");
    ioWrite(IA, 8'h31, 1'b0, 8'h00, "R2 locked index write");

    // R3: interrupted key sequence restarts
    ioWrite(IA, 8'h87, 1'b0, 8'h00, "R3 key one");
    ioWrite(IA, 8'h12, 1'b0, 8'h00, "R3 break");
    ioWrite(IA, 8'h87, 1'b0, 8'h00, "R3 key restart");
    ioRead(DA, 8'hFF, "R3 still locked after broken sequence");
    ioWrite(IA, 8'h87, 1'b0, 8'h00, "R3 key two");
    ioRead(IA, 8'h00, "R1 index zero after reset and R2 locked write ignored");

    // R1 / R6: logical device register
    ioWrite(IA, 8'h07, 1'b0, 8'h00, "R6 select ldn");
    dut_idx_exp = 8'h07;
    ioRead(DA, 8'h00, "R1 ldn zero after reset");
    ioWrite(DA, 8'h06, 1'b0, 8'h00, "R6 ldn write");
    ioRead(DA, 8'h06, "R6 ldn readback");
    ioRead(IA, 8'h07, "R6 index readback");

    // R7 / R8: identification
    ioWrite(IA, 8'h20, 1'b0, 8'h00, "R7 idx"); ioRead(DA, 8'h5A, "R7 chip id high");
    ioWrite(IA, 8'h21, 1'b0, 8'h00, "R7 idx"); ioRead(DA, 8'h3C, "R7 chip id low");
    ioWrite(IA, 8'h22, 1'b0, 8'h00, "R7 idx"); ioRead(DA, 8'h11, "R7 revision");
    ioWrite(IA, 8'h23, 1'b0, 8'h00, "R8 idx"); ioRead(DA, 8'h19, "R8 vendor high");
    ioWrite(IA, 8'h24, 1'b0, 8'h00, "R8 idx"); ioRead(DA, 8'h34, "R8 vendor low");

    // R10: unassigned global index
    ioWrite(IA, 8'h10, 1'b0, 8'h00, "R10 idx");
    dut_idx_exp = 8'h10;
    ioRead(DA, 8'hFF, "R10 unassigned read");
    ioWrite(DA, 8'h77, 1'b0, 8'h06, "R10 unassigned write no strobe");
    ioWrite(IA, 8'h07, 1'b0, 8'h00, "R10 idx");
    ioRead(DA, 8'h06, "R10 ldn unchanged");

    // R9: forwarding
    ioWrite(IA, 8'h31, 1'b0, 8'h00, "R9 idx");
    dut_idx_exp = 8'h31;
    ioWrite(DA, 8'hC3, 1'b1, 8'h06, "R9 forwarded write");
    ioRead(DA, 8'h94, "R9 forwarded read");
    ioWrite(IA, 8'h30, 1'b0, 8'h00, "R9 idx");
    dut_idx_exp = 8'h30;
    ioWrite(DA, 8'h01, 1'b1, 8'h06, "R9 forwarded write at first device index");
    ioWrite(IA, 8'h31, 1'b0, 8'h00, "R9 idx");
    dut_idx_exp = 8'h31;

    // R5: other port pair ignored
    ioWrite(IB, 8'hAA, 1'b0, 8'h00, "R5 exit key on inactive pair");
    ioWrite(DB, 8'h22, 1'b0, 8'h00, "R5 data write on inactive pair");
    ioRead(DB, 8'hFF, "R5 inactive data port reads idle");
    ioRead(DA, 8'h94, "R5 still open after inactive-pair exit key");

    // R4: exit key locks, state retained
    ioWrite(IA, 8'hAA, 1'b0, 8'h00, "R4 exit key");
    ioRead(DA, 8'hFF, "R4 locked after exit key");
    ioWrite(IA, 8'h87, 1'b0, 8'h00, "R4 reopen");
    ioWrite(IA, 8'h87, 1'b0, 8'h00, "R4 reopen");
    ioRead(IA, 8'h31, "R4 index retained across lock");

    // R5: switch to the second port pair
    baseSel = 1'b1;
    ioRead(IB, 8'h31, "R5 second pair index port");
    ioRead(DB, 8'h94, "R5 second pair data port");
    ioRead(IA, 8'hFF, "R5 first pair ignored when second selected");
    ioWrite(DA, 8'h44, 1'b0, 8'h00, "R5 first pair write ignored");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads pending expected 0", expQ.size());
    end
    finish_run();
  end

endmodule